// File: doc/BRIEF.md
# Per-Processor GPIO Interrupt Cause and Mask Banks

This block gives each of four processors a private copy of the GPIO interrupt state: an edge-cause register, an edge-mask register and a level-mask register. The copies live in a small register window of their own. The port logic upstream supplies two vectors. One is the line level, already synchronised and polarity-adjusted. The other is a per-line edge event pulse. The block turns these into per-processor summary interrupt lines.

An edge event is latched into every processor's cause copy at once. Each processor acknowledges only its own copy, so servicing on one processor leaves the others' pending state untouched. A processor's cause vector combines two sources: the level lines it has enabled, and the latched edges it has enabled. The lines are OR-reduced in groups of eight, and each group drives one summary output per processor.

Top module: `percpu_irq_bank`

## Requirements
- R1: After reset, every cause, edge-mask and level-mask register reads zero and every summary output is low, whatever the line levels are.
- R2: The window uses byte offsets on a 6-bit address. Processor n's edge-cause register is at 4·n, its edge-mask register at 0x10 + 4·n, and its level-mask register at 0x20 + 4·n, for n from 0 to 3. Bit i of each register belongs to line i.
- R3: A write to a mask register replaces the whole register, and the new value reads back from the cycle after the write.
- R4: An edge event on line i sets bit i in all four processors' cause registers at the next clock edge.
- R5: A write to processor n's cause register clears each bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1. The other processors' cause registers are unchanged.
- R6: An edge event arriving in the same cycle as a clearing write leaves its bit set.
- R7: Processor n's pending vector is (line level AND level mask n) OR (edge cause n AND edge mask n). Summary output n·4 + g is the OR of pending lines 8·g to 8·g+7. Level changes reach the outputs without a clock delay.
- R8: Reads of any offset not listed in R2 (offsets that are not a multiple of 4, or offsets from 0x30 up) return zero. Writes to those offsets change no register.
- R9: One processor's masks and cause bits have no effect on any other processor's summary outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| line_level | input | 32 | Synchronised, polarity-adjusted line levels |
| line_edge | input | 32 | One-cycle edge event per line |
| cpu_irq | output | 16 | Summary outputs, index cpu·4 + group |

## Verification
Single-line level masks are swept over every line and processor while all line levels are high. This shows whether a line lands on the correct group output of the correct processor and of no other processor. Inverted line levels then show that the output follows the level and not the mask alone. One-hot edge pulses are followed by partial acknowledges from one processor. They separate shared latching from private clearing, and a clearing write in the same cycle as a new event tests event priority. A full sweep of the 64 offsets separates mapped from unmapped decode in both the read and the write direction.

// File: rtl/percpu_irq_bank.sv
module percpu_irq_bank #(
  parameter int NLINES = 32,
  parameter int NCPU   = 4,
  parameter int GROUP  = 8,
  parameter int AW     = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [NLINES-1:0]       bus_wdata,
  output logic [NLINES-1:0]       bus_rdata,
  input  logic [NLINES-1:0]       line_level,
  input  logic [NLINES-1:0]       line_edge,
  output logic [NCPU*(NLINES/GROUP)-1:0] cpu_irq
);
  localparam int NGRP = NLINES / GROUP;

  logic [NCPU-1:0][NLINES-1:0] cause_q, emask_q, lmask_q, pend;
  logic [1:0] sel_kind, sel_cpu;
  logic       hi_zero, hit;

  assign sel_kind = bus_addr[5:4];
  assign sel_cpu  = bus_addr[3:2];

  if (AW > 6) begin : g_hi
    assign hi_zero = ~|bus_addr[AW-1:6];
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end

  assign hit = hi_zero && (bus_addr[1:0] == 2'b00) && (sel_kind != 2'd3)
               && (int'(sel_cpu) < NCPU);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic mine;
    assign mine = bus_wr && hit && (int'(sel_cpu) == c);

    always_ff @(posedge clk) begin
      if (rst) begin
        cause_q[c] <= '0;
        emask_q[c] <= '0;
        lmask_q[c] <= '0;
      end else begin
        cause_q[c] <= ((mine && sel_kind == 2'd0) ? (cause_q[c] & bus_wdata) : cause_q[c])
                      | line_edge;
        if (mine && sel_kind == 2'd1) emask_q[c] <= bus_wdata;
        if (mine && sel_kind == 2'd2) lmask_q[c] <= bus_wdata;
      end
    end

    assign pend[c] = (line_level & lmask_q[c]) | (cause_q[c] & emask_q[c]);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign cpu_irq[c*NGRP+g] = |pend[c][g*GROUP +: GROUP];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (hit && int'(sel_cpu) == c) begin
        case (sel_kind)
          2'd0:    bus_rdata = cause_q[c];
          2'd1:    bus_rdata = emask_q[c];
          2'd2:    bus_rdata = lmask_q[c];
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

module percpu_irq_bank_chk #(
  parameter int NLINES = 32,
  parameter int NCPU   = 4,
  parameter int GROUP  = 8,
  parameter int AW     = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_wr,
  input logic [AW-1:0]           bus_addr,
  input logic [NLINES-1:0]       bus_wdata,
  input logic [NLINES-1:0]       bus_rdata,
  input logic [NLINES-1:0]       line_edge,
  input logic [NCPU*(NLINES/GROUP)-1:0] cpu_irq,
  input logic [NCPU-1:0][NLINES-1:0] cause,
  input logic [NCPU-1:0][NLINES-1:0] emask,
  input logic [NCPU-1:0][NLINES-1:0] lmask
);
  logic unmapped;
  assign unmapped = (bus_addr[1:0] != 2'b00) || (int'(bus_addr) >= 'h30)
                    || (int'(bus_addr[3:2]) >= NCPU);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cause == '0 && emask == '0 && lmask == '0));

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> bus_rdata == '0);

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && unmapped) |=> ($stable(emask) && $stable(lmask)));

  assert_no_mask_no_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (emask == '0 && lmask == '0) |-> cpu_irq == '0);

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    assert_edge_sets_all_R4: assert property (@(posedge clk) disable iff (rst)
      (|line_edge) |=> ((cause[c] & $past(line_edge)) == $past(line_edge)));

    assert_clear_own_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && int'(bus_addr) == 4*c && bus_wdata == '0 && line_edge == '0)
      |=> cause[c] == '0);
  end
endmodule

bind percpu_irq_bank percpu_irq_bank_chk #(
  .NLINES(NLINES), .NCPU(NCPU), .GROUP(GROUP), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_edge(line_edge),
  .cpu_irq(cpu_irq), .cause(cause_q), .emask(emask_q), .lmask(lmask_q)
);

// File: tb/test_percpu_irq_bank.sv
module test_percpu_irq_bank;
  localparam int NL = 32, NC = 4, NG = 4;

  logic          clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [NL-1:0] bus_wdata = '0, bus_rdata, line_level = '0, line_edge = '0;
  logic [NC*NG-1:0] cpu_irq;

  int checks = 0, fails = 0;
  logic [NL-1:0] mc [NC], mem [NC], mlm [NC];

  always #5 clk = ~clk;

  percpu_irq_bank i_percpu_irq_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_level(line_level),
    .line_edge(line_edge), .cpu_irq(cpu_irq)
  );

  function automatic bit mapped(int a);
    return (a % 4 == 0) && (a < 'h30);
  endfunction

  function automatic logic [NC*NG-1:0] exp_irq();
    logic [NC*NG-1:0] r = '0;
    for (int c = 0; c < NC; c++) begin
      logic [NL-1:0] p = (line_level & mlm[c]) | (mc[c] & mem[c]);
      for (int g = 0; g < NG; g++) r[c*NG+g] = |((p >> (8*g)) & 32'hFF);
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit wr, int a, logic [NL-1:0] d, logic [NL-1:0] ev);
    @(negedge clk);
    bus_wr = wr; bus_addr = 6'(a); bus_wdata = d; line_edge = ev;
    @(negedge clk);
    bus_wr = 1'b0; line_edge = '0;
    if (wr && mapped(a)) begin
      case (a / 16)
        0: mc[(a % 16) / 4] &= d;
        1: mem[(a % 16) / 4] = d;
        default: mlm[(a % 16) / 4] = d;
      endcase
    end
    for (int c = 0; c < NC; c++) mc[c] |= ev;
  endtask

  task automatic rd(int a, output logic [NL-1:0] v);
    bus_addr = 6'(a);
    #1 v = bus_rdata;
  endtask

  task automatic check_regs(string tag);
    logic [NL-1:0] v;
    for (int c = 0; c < NC; c++) begin
      rd(4*c, v);         chk({tag, " cause"}, v, mc[c]);
      rd('h10 + 4*c, v);  chk({tag, " emask"}, v, mem[c]);
      rd('h20 + 4*c, v);  chk({tag, " lmask"}, v, mlm[c]);
    end
  endtask

  task automatic check_irq(string tag);
    #1 chk(tag, 32'(cpu_irq), 32'(exp_irq()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin mc[c] = '0; mem[c] = '0; mlm[c] = '0; end
    line_level = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_regs("R1 reset");
    check_irq("R1 reset irq");

    for (int c = 0; c < NC; c++) begin
      step(1, 'h10 + 4*c, 32'h1234_5670 ^ (32'h1111_1111 * c), '0);
      step(1, 'h20 + 4*c, 32'h8000_0001 << c, '0);
    end
    check_regs("R2 R3 readback");
    step(1, 'h14, 32'h0000_FFFF, '0);
    check_regs("R3 replace");
    for (int c = 0; c < NC; c++) begin
      step(1, 'h10 + 4*c, '0, '0);
      step(1, 'h20 + 4*c, '0, '0);
    end

    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < NL; i++) begin
        line_level = '1;
        step(1, 'h20 + 4*c, 32'h1 << i, '0);
        check_irq("R7 R9 level sweep");
        line_level = ~(32'h1 << i);
        check_irq("R7 level low");
      end
      step(1, 'h20 + 4*c, '0, '0);
    end
    line_level = '0;

    for (int c = 0; c < NC; c++) step(1, 'h10 + 4*c, '1, '0);
    for (int i = 0; i < NL; i++) begin
      step(0, 0, '0, 32'h1 << i);
      check_regs("R4 edge latch");
      check_irq("R4 R7 edge irq");
      step(1, 4*(i % NC), ~(32'h1 << i), '0);
      check_regs("R5 own clear");
      check_irq("R5 R9 irq after clear");
    end
    step(1, 4, 32'h0000_0300, '0);
    check_regs("R5 keep ones");
    step(1, 8, '0, 32'h0000_0060);
    check_regs("R6 event vs clear");
    step(1, 4, '0, 32'h0001_0000);
    check_regs("R6 event wins");
    check_irq("R6 irq");

    step(1, 'h24, 32'h00F0_000F, '0);
    for (int a = 0; a < 64; a++) begin
      if (!mapped(a)) begin
        logic [NL-1:0] v;
        step(1, a, '1, '0);
        rd(a, v);
        chk("R8 unmapped read", v, '0);
      end
    end
    check_regs("R8 after unmapped writes");
    check_irq("R8 irq");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule